// File: doc/BRIEF.md
# Emulation Mode Chip-Select Decoder

This block decides, once per reset, whether the surrounding bus interface runs in normal mode, in emulator mode, in ROM-emulation mode, or in both emulation modes at once. It reads three configuration levels while reset is held: two bits of the data bus and the bus-error pin. It keeps the result until the next reset. In emulator mode the bus runs as a 16-bit expanded bus. Cycles that address one of the externally mapped peripheral port registers drive an active-low emulator chip select, so an external port-replacement circuit can answer. At the same time the block tells the internal port logic to stay silent. A fixed access of three clocks is marked by a one-clock terminate pulse.

In ROM-emulation mode, cycles that fall inside the ROM address window drive an active-low memory chip select. The block also withholds the internal ROM acknowledge, so the bus engine runs an external cycle. A build for flash-based memory keeps the memory select high at all times.

Every pin is a plain control level. No data stream passes through the block, so no valid/ready handshake is used and no back-pressure applies. The chip selects follow the address strobe without any clock delay.

Top module: `emu_csel_top`

## Requirements
- R1: While `rst_n` is low, emulator mode is sampled as true when `strap_data[10]` is 0, `strap_data[1]` is 0 and `buserr_lvl` is 1. After reset is released the mode is held, and later changes on these pins have no effect. `exp16_mode` shows emulator mode and is 0 during reset.
- R2: ROM-emulation mode is sampled as true when `strap_data[1]`, `strap_data[10]` and `strap_data[13]` are all 0 and `buserr_lvl` is 1. If `buserr_lvl` is 0, ROM emulation stays off.
- R3: In emulator mode, `emu_cs_n` is 0 exactly while `as_n` is 0 and `addr` (bit 0 ignored) matches one of the 11 externally mapped port registers. With the default map these are 0xFFFA10 to 0xFFFA24 in steps of 2. `emu_cs_n` returns to 1 as soon as `as_n` rises.
- R4: The registers kept internal never assert `emu_cs_n`. With the default map these are 0xFFFA26, 0xFFFA28, 0xFFFA2A and 0xFFFA2C. For these registers `int_port_hold` stays 0.
- R5: `int_port_hold` is 1 whenever emulator mode is active, reset is released and `addr` matches an externally mapped register. It is 0 otherwise.
- R6: `ext_term` is 1 for exactly the third clock of a strobe (counted from the first rising clock edge with `as_n` low) during an externally mapped access. It is 0 in all other cycles.
- R7: In ROM-emulation mode with `FLASH_ROM`=0, `mem_cs_n` is 0 while `as_n` is 0 and `ROM_BASE <= addr < ROM_BASE+ROM_SIZE`. The defaults are 0x020000 and 0x008000. `rom_ack_hold` is 1 whenever ROM-emulation mode is active and `addr` is in the window.
- R8: With `FLASH_ROM`=1, `mem_cs_n` is 1 at all times.
- R9: During reset, and in normal mode, `emu_cs_n` and `mem_cs_n` are 1 and both hold outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; the configuration levels are sampled while it is low |
| strap_data | input | 16 | Data bus levels used for mode configuration |
| buserr_lvl | input | 1 | Bus-error pin level used for mode configuration |
| addr | input | ADDR_W | Bus address |
| as_n | input | 1 | Active-low address strobe |
| emu_cs_n | output | 1 | Emulator chip select, active low |
| mem_cs_n | output | 1 | ROM-window memory chip select, active low |
| int_port_hold | output | 1 | Suppresses the internal port-register response |
| rom_ack_hold | output | 1 | Withholds the internal ROM acknowledge |
| ext_term | output | 1 | Marks the third clock of an external register access |
| exp16_mode | output | 1 | Emulator mode (16-bit expanded bus) is active |

## Verification
A wrong latched mode bit shows up in the very first strobe after reset, as a select or hold that appears when it should not or fails to appear. `exp16_mode` shows it even before any strobe. A miscounted access timer moves or repeats `ext_term` within the same strobe, by the third or fourth clock. A wrong entry in the register map or a wrong window bound shows as a select level that differs from the bench's address-based model on the same cycle in which that address is strobed.

// File: rtl/emu_csel_pkg.sv
package emu_csel_pkg;

  // Strap positions are fixed by the configuration convention.
  localparam int STRAP_LO  = 1;
  localparam int STRAP_MID = 10;
  localparam int STRAP_HI  = 13;

  typedef struct packed {
    logic emu;
    logic romemu;
  } emu_mode_t;

  function automatic emu_mode_t decode_straps(input logic [15:0] d, input logic berr_hi);
    emu_mode_t m;
    m.emu    = !d[STRAP_MID] && !d[STRAP_LO] && berr_hi;
    m.romemu = !d[STRAP_MID] && !d[STRAP_LO] && !d[STRAP_HI] && berr_hi;
    return m;
  endfunction

endpackage

// File: rtl/emu_mode_latch.sv
module emu_mode_latch
  import emu_csel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] strap_data,
  input  logic        buserr_lvl,
  output emu_mode_t   mode_q
);
  // Tracks the straps throughout reset; the last sample before release is kept.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= decode_straps(strap_data, buserr_lvl);
  end
endmodule

// File: rtl/emu_reg_match.sv
module emu_reg_match #(
  parameter int                          ADDR_W   = 24,
  parameter int                          NUM_REGS = 11,
  parameter logic [NUM_REGS*ADDR_W-1:0]  REG_MAP  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [NUM_REGS-1:0] match;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    // Word-wide registers: the byte select bit takes no part in the match.
    assign match[i] = (addr[ADDR_W-1:1] == REG_MAP[i*ADDR_W+1 +: ADDR_W-1]);
  end

  assign hit = |match;
endmodule

// File: rtl/emu_rom_window.sv
module emu_rom_window #(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE = '0,
  parameter logic [ADDR_W-1:0] ROM_SIZE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, ROM_BASE} + {1'b0, ROM_SIZE};

  assign in_win = (addr >= ROM_BASE) && ({1'b0, addr} < WIN_END);
endmodule

// File: rtl/emu_ext_timer.sv
module emu_ext_timer #(
  parameter int ACC_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic term
);
  localparam int CW = $clog2(ACC_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !active)            cnt <= '0;
    else if (cnt != CW'(ACC_CLKS))    cnt <= cnt + 1'b1;
  end

  assign term = active && (cnt == CW'(ACC_CLKS - 1));
endmodule

// File: rtl/emu_csel_top.sv
module emu_csel_top
  import emu_csel_pkg::*;
#(
  parameter int                        ADDR_W    = 24,
  parameter int                        NUM_EXT   = 11,
  parameter logic [NUM_EXT*ADDR_W-1:0] EXT_MAP   = {24'hFFFA24, 24'hFFFA22, 24'hFFFA20,
                                                    24'hFFFA1E, 24'hFFFA1C, 24'hFFFA1A,
                                                    24'hFFFA18, 24'hFFFA16, 24'hFFFA14,
                                                    24'hFFFA12, 24'hFFFA10},
  parameter logic [ADDR_W-1:0]         ROM_BASE  = 24'h020000,
  parameter logic [ADDR_W-1:0]         ROM_SIZE  = 24'h008000,
  parameter int                        ACC_CLKS  = 3,
  parameter bit                        FLASH_ROM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       strap_data,
  input  logic              buserr_lvl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  output logic              emu_cs_n,
  output logic              mem_cs_n,
  output logic              int_port_hold,
  output logic              rom_ack_hold,
  output logic              ext_term,
  output logic              exp16_mode
);
  emu_mode_t mode_q;
  logic      reg_hit, rom_hit;
  logic      ext_sel, rom_sel, strobe;

  emu_mode_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_data (strap_data),
    .buserr_lvl (buserr_lvl),
    .mode_q     (mode_q)
  );

  emu_reg_match #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_EXT), .REG_MAP(EXT_MAP)) u_match (
    .addr (addr),
    .hit  (reg_hit)
  );

  emu_rom_window #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)) u_win (
    .addr   (addr),
    .in_win (rom_hit)
  );

  assign strobe  = rst_n && !as_n;
  assign ext_sel = rst_n && mode_q.emu && reg_hit;
  assign rom_sel = rst_n && mode_q.romemu && rom_hit;

  emu_ext_timer #(.ACC_CLKS(ACC_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (strobe && ext_sel),
    .term   (ext_term)
  );

  assign emu_cs_n      = !(strobe && ext_sel);
  assign int_port_hold = ext_sel;
  assign rom_ack_hold  = rom_sel;
  assign exp16_mode    = rst_n && mode_q.emu;

  if (FLASH_ROM) begin : g_flash
    assign mem_cs_n = 1'b1;
  end else begin : g_rom
    assign mem_cs_n = !(strobe && rom_sel);
  end
endmodule

// File: rtl/emu_csel_chk.sv
module emu_csel_chk #(
  parameter bit FLASH_ROM = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic emu_cs_n,
  input logic mem_cs_n,
  input logic int_port_hold,
  input logic rom_ack_hold,
  input logic ext_term,
  input logic exp16_mode
);
  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) as_n |-> (emu_cs_n && mem_cs_n));
  // R5
  hold_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !emu_cs_n |-> int_port_hold);
  // R7
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> rom_ack_hold);
  // R6
  term_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) ext_term |-> !emu_cs_n);
  // R6
  term_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ext_term |=> !ext_term);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> $stable(exp16_mode));
  // R9
  no_emu_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !exp16_mode |-> emu_cs_n);
  // R8
  if (FLASH_ROM) begin : g_flash_chk
    flash_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n);
  end
endmodule

bind emu_csel_top emu_csel_chk #(.FLASH_ROM(FLASH_ROM)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .as_n          (as_n),
  .emu_cs_n      (emu_cs_n),
  .mem_cs_n      (mem_cs_n),
  .int_port_hold (int_port_hold),
  .rom_ack_hold  (rom_ack_hold),
  .ext_term      (ext_term),
  .exp16_mode    (exp16_mode)
);

// File: tb/emu_csel_top_bench.sv
module emu_csel_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] strap_data = 16'hFFFF;
  logic        buserr_lvl = 1'b1;
  logic [23:0] addr = 24'h0;
  logic        as_n = 1'b1;

  logic emu_cs_n, mem_cs_n, int_port_hold, rom_ack_hold, ext_term, exp16_mode;
  logic f_emu_cs_n, f_mem_cs_n, f_int_port_hold, f_rom_ack_hold, f_ext_term, f_exp16_mode;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  emu_csel_top u_emu_csel_top (
    .clk(clk), .rst_n(rst_n), .strap_data(strap_data), .buserr_lvl(buserr_lvl),
    .addr(addr), .as_n(as_n), .emu_cs_n(emu_cs_n), .mem_cs_n(mem_cs_n),
    .int_port_hold(int_port_hold), .rom_ack_hold(rom_ack_hold),
    .ext_term(ext_term), .exp16_mode(exp16_mode)
  );

  emu_csel_top #(.FLASH_ROM(1'b1)) u_emu_csel_top_flash (
    .clk(clk), .rst_n(rst_n), .strap_data(strap_data), .buserr_lvl(buserr_lvl),
    .addr(addr), .as_n(as_n), .emu_cs_n(f_emu_cs_n), .mem_cs_n(f_mem_cs_n),
    .int_port_hold(f_int_port_hold), .rom_ack_hold(f_rom_ack_hold),
    .ext_term(f_ext_term), .exp16_mode(f_exp16_mode)
  );

  // Reference model
  logic [23:0] ext_q[$];
  logic [23:0] int_q[$];
  bit m_emu = 1'b0, m_rom = 1'b0;
  int clks_low = 0;

  function automatic bit in_list(input logic [23:0] a, input logic [23:0] q[$]);
    foreach (q[k]) if ({a[23:1], 1'b0} == q[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit in_rom(input logic [23:0] a);
    return (a >= 24'h020000) && (a < 24'h028000);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_emu    <= !strap_data[10] && !strap_data[1] && buserr_lvl;
      m_rom    <= !strap_data[10] && !strap_data[1] && !strap_data[13] && buserr_lvl;
      clks_low <= 0;
    end else if (!as_n && m_emu && in_list(addr, ext_q)) begin
      clks_low <= clks_low + 1;
    end else begin
      clks_low <= 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h as_n=%b actual=%b expected=%b t=%0t", tag, addr, as_n, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit up, ext, intr, rw, e_cs, e_mcs, e_ih, e_rh, e_term;
      string cs_tag;
      up     = rst_n;
      ext    = up && m_emu && in_list(addr, ext_q);
      intr   = in_list(addr, int_q);
      rw     = up && m_rom && in_rom(addr);
      e_cs   = !(ext && !as_n);
      e_mcs  = !(rw && !as_n);
      e_ih   = ext;
      e_rh   = rw;
      e_term = ext && !as_n && (clks_low == 2);
      cs_tag = (!up || !m_emu) ? "R9 emu_cs" : (intr ? "R4 emu_cs" : "R3 emu_cs");
      chk(cs_tag, emu_cs_n, e_cs);
      chk(intr ? "R4 int_hold" : "R5 int_hold", int_port_hold, e_ih);
      chk("R6 ext_term", ext_term, e_term);
      chk("R1 R10 exp16", exp16_mode, up && m_emu);
      chk(m_rom ? "R2 R7 mem_cs" : "R9 mem_cs", mem_cs_n, e_mcs);
      chk("R7 rom_hold", rom_ack_hold, e_rh);
      chk("R8 flash mem_cs", f_mem_cs_n, 1'b1);
      chk("R3 flash emu_cs", f_emu_cs_n, e_cs);
      chk("R6 flash term", f_ext_term, e_term);
    end
  end

  task automatic do_reset(input logic [15:0] d, input logic be);
    rst_n = 1'b0;
    as_n = 1'b1;
    strap_data = d;
    buserr_lvl = be;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // Pins move after release: must not alter the latched mode (R1).
    strap_data = ~d;
    buserr_lvl = ~be;
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(input logic [23:0] a, input int n);
    addr = a;
    as_n = 1'b0;
    repeat (n) @(posedge clk);
    #1;
    as_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic sweep();
    foreach (ext_q[k]) cyc(ext_q[k] | 24'(k % 2), 4);
    foreach (int_q[k]) cyc(int_q[k], 3);
    cyc(24'h020000, 3);
    cyc(24'h027FFF, 3);
    cyc(24'h028000, 3);
    cyc(24'h01FFFF, 3);
    cyc(24'hFFFA0E, 3);
    cyc(24'hFFFA12, 2);
    cyc(24'hFFFA14, 7);
    for (int k = 0; k < 6; k++) cyc(24'hFFFA00 + 24'($urandom_range(0, 63)), 1 + (k % 5));
  endtask

  initial begin
    for (int k = 0; k < 11; k++) ext_q.push_back(24'hFFFA10 + 24'(2 * k));
    for (int k = 0; k < 4; k++)  int_q.push_back(24'hFFFA26 + 24'(2 * k));
    @(posedge clk);
    #1;
    do_reset(16'hFFFF, 1'b1);                          // normal
    sweep();
    do_reset(16'hFFFF & ~16'h0402, 1'b1);              // emulator only
    sweep();
    do_reset(16'hFFFF & ~16'h2402, 1'b1);              // emulator and ROM emulation
    sweep();
    do_reset(16'hFFFF & ~16'h2402, 1'b0);              // bus error low: normal
    sweep();
    do_reset(16'hFFFF & ~16'h0002, 1'b1);              // data bit 10 high: normal
    sweep();
    do_reset(16'h0000, 1'b1);                          // all straps low
    sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule